// File: doc/BRIEF.md
# Outbound Mailbox Channel Dispatcher

This block sits behind a host register window and forwards 32-bit message words to a set of channel ports. The host writes a word into one of four submission offsets. The low nibble of that word selects the target channel.

If the selected channel reports that it is idle, the whole word is placed on that channel's data bus and the channel's write strobe pulses for one cycle. If the channel reports that it is busy, the word is appended to a small deferred queue instead. The host can poll the queue's full and empty state through a status register.

Submissions are dropped in two cases: when the queue is already full, and when the nibble names a channel that does not exist. Each kind of drop sets its own sticky diagnostic flag. Emptying the queue toward channels is handled elsewhere.

A small outcome state machine records the result of the most recent submission. The states are:
- `ST_IDLE`: no submission arrived in the last cycle.
- `ST_SEND`: direct delivery; the strobe of the chosen channel is high.
- `ST_DEFER`: the word was queued.
- `ST_DROP_FULL`: the queue was full.
- `ST_DROP_CHAN`: the channel number was out of range.

The state is re-evaluated every cycle. Any state moves to `ST_IDLE` when no submission is present. Otherwise the next state is picked by a fixed priority: queue full, then channel out of range, then channel busy, and `ST_SEND` when none of these holds.

Top module: `mbox_out_dispatch`

## Requirements
- R1: A write is a submission only when the low 8 address bits are 0xA0, 0xA4, 0xA8 or 0xAC. Writes to any other offset, including unaligned offsets such as 0xA2, change no output and no queue state.
- R2: The target channel is bits [3:0] of the written word. A value of NCHAN or more is discarded without a strobe and sets `drop_chan_flag`.
- R3: A submission to an idle, valid channel c raises only `ch_we[c]`, in the cycle after the write, for exactly one cycle. In that cycle the slice `ch_data[c*32 +: 32]` holds the full written word.
- R4: A submission to a valid channel whose `ch_busy` bit is high produces no strobe and appends the word to the deferred queue, which then reads as not empty.
- R5: While the queue holds DEPTH words, every submission is dropped and sets `drop_full_flag`, even when the target channel is idle. The queue stays full.
- R6: A read whose low 8 address bits are 0xB8 returns, in the cycle after the read, bit 31 = queue full, bit 30 = queue empty, and all other bits zero. Any other read returns zero.
- R7: Reset empties the queue, refills every slot with the sentinel word 0xFFFFFFFF, clears both flags, lowers all strobes and zeroes `rdata`.
- R8: Both drop flags stay set once raised, until the next reset.
- R9: Only the low 8 address bits are decoded. For example, 0x1A4 submits and 0x3B8 reads the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data / message word |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| ch_busy | input | NCHAN | Per-channel busy (pending) indication |
| ch_we | output | NCHAN | Per-channel one-cycle write strobe |
| ch_data | output | NCHAN*32 | Per-channel data buses, channel c at bits c*32 +: 32 |
| drop_full_flag | output | 1 | Sticky: a submission was dropped because the queue was full |
| drop_chan_flag | output | 1 | Sticky: a submission named a nonexistent channel |

## Verification
A wrong queue count shows at the status register on the very next read: full appears too early or too late, or empty fails to clear after the first deferred word. A wrong outcome state shows one cycle after the offending write, either as a strobe that should not be there, a strobe on the wrong channel, or a drop flag that is raised or missing. Because both flags are sticky, a single misrouted drop stays visible at the ports until reset.

// File: rtl/mbox_out_pkg.sv
package mbox_out_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_DEFER,
        ST_DROP_FULL,
        ST_DROP_CHAN
    } route_state_e;

    localparam logic [31:0] EMPTY_SLOT_WORD = 32'hFFFF_FFFF;
    localparam logic [7:0]  SUBMIT_FIRST    = 8'hA0;
    localparam logic [7:0]  SUBMIT_LAST     = 8'hAC;
    localparam logic [7:0]  STATUS_OFS      = 8'hB8;
    localparam int          STAT_FULL_BIT   = 31;
    localparam int          STAT_EMPTY_BIT  = 30;

endpackage

// File: rtl/mbox_out_decode.sv
module mbox_out_decode
    import mbox_out_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              submit,
    output logic              stat_rd
);
    logic [7:0] ofs;
    logic       in_range;
    logic       aligned;

    // Offsets wrap every 256 bytes.
    always_comb begin
        ofs      = addr[7:0];
        in_range = (ofs >= SUBMIT_FIRST) && (ofs <= SUBMIT_LAST);
        aligned  = (ofs[1:0] == 2'b00);
        submit   = wr_en && in_range && aligned;
        stat_rd  = rd_en && (ofs == STATUS_OFS);
    end

endmodule

// File: rtl/mbox_defer_queue.sv
module mbox_defer_queue
    import mbox_out_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    output logic              full,
    output logic              empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] slot [DEPTH];
    logic [CNT_W-1:0]  count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot[i] <= DATA_W'(EMPTY_SLOT_WORD);
            end
        end else if (push && !full) begin
            slot[IDX_W'(count)] <= push_data;
            count               <= count + 1'b1;
        end
    end

    always_comb begin
        full  = (count == CNT_W'(DEPTH));
        empty = (count == '0);
    end

    // The count never exceeds the depth (R5).
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // The router never pushes into a full queue (R5).
    p_push_not_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // Each accepted push raises the count by one (R4).
    p_push_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (count == $past(count) + 1'b1));

    // The first unused slot still holds the sentinel (R7).
    p_slot_sentinel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count < CNT_W'(DEPTH)) |-> (slot[IDX_W'(count)] == DATA_W'(EMPTY_SLOT_WORD)));

endmodule

// File: rtl/mbox_route_fsm.sv
module mbox_route_fsm
    import mbox_out_pkg::*;
#(
    parameter int NCHAN  = 9,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    submit,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NCHAN-1:0]        ch_busy,
    input  logic                    q_full,
    output logic                    q_push,
    output logic [DATA_W-1:0]       q_word,
    output logic [NCHAN-1:0]        ch_we,
    output logic [NCHAN*DATA_W-1:0] ch_data,
    output logic                    drop_full,
    output logic                    drop_chan
);
    route_state_e state, state_nx;
    logic [3:0]   chan_in;
    logic [3:0]   chan_q;
    logic         chan_ok;
    logic         busy_sel;

    // Decode the channel nibble and the busy bit of the selected channel.
    always_comb begin
        chan_in  = wdata[3:0];
        chan_ok  = (32'(chan_in) < NCHAN);
        busy_sel = 1'b0;
        for (int i = 0; i < NCHAN; i++) begin
            if (32'(chan_in) == i) begin
                busy_sel = ch_busy[i];
            end
        end
    end

    // Next state, by priority: queue full, bad channel, busy, send.
    always_comb begin
        if (!submit) begin
            state_nx = ST_IDLE;
        end else if (q_full) begin
            state_nx = ST_DROP_FULL;
        end else if (!chan_ok) begin
            state_nx = ST_DROP_CHAN;
        end else if (busy_sel) begin
            state_nx = ST_DEFER;
        end else begin
            state_nx = ST_SEND;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            chan_q <= '0;
        end else begin
            state  <= state_nx;
            chan_q <= chan_in;
        end
    end

    // The queue is written on the same edge that enters ST_DEFER.
    always_comb begin
        q_push = (state_nx == ST_DEFER);
        q_word = wdata;
    end

    // Strobes and flags, derived from the current state.
    always_comb begin
        ch_we = '0;
        unique case (state)
            ST_SEND: begin
                for (int i = 0; i < NCHAN; i++) begin
                    ch_we[i] = (32'(chan_q) == i);
                end
            end
            ST_IDLE, ST_DEFER, ST_DROP_FULL, ST_DROP_CHAN: ch_we = '0;
            default: ch_we = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_full <= 1'b0;
            drop_chan <= 1'b0;
        end else begin
            if (state_nx == ST_DROP_FULL) begin
                drop_full <= 1'b1;
            end
            if (state_nx == ST_DROP_CHAN) begin
                drop_chan <= 1'b1;
            end
        end
    end

    // One data register per channel, loaded only on a direct delivery.
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if ((state_nx == ST_SEND) && (32'(chan_in) == c)) begin
                word_q <= wdata;
            end
        end
        assign ch_data[c*DATA_W +: DATA_W] = word_q;
    end

    // At most one strobe is high at any time (R3).
    p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_we));

    // A full queue drops the word and raises the flag (R5).
    p_full_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (submit && q_full) |=> (drop_full && (ch_we == '0)));

    // A busy target produces no strobe (R4).
    p_busy_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (submit && !q_full && chan_ok && busy_sel) |=> (ch_we == '0));

    // The flags are sticky (R8).
    p_sticky_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop_full |=> drop_full);
    p_sticky_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop_chan |=> drop_chan);

endmodule

// File: rtl/mbox_out_dispatch.sv
module mbox_out_dispatch
    import mbox_out_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCHAN  = 9,
    parameter int DEPTH  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NCHAN-1:0]    ch_busy,
    output logic [NCHAN-1:0]    ch_we,
    output logic [NCHAN*32-1:0] ch_data,
    output logic                drop_full_flag,
    output logic                drop_chan_flag
);
    localparam int DATA_W = 32;

    logic              submit;
    logic              stat_rd;
    logic              q_push;
    logic [DATA_W-1:0] q_word;
    logic              q_full;
    logic              q_empty;

    mbox_out_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .submit  (submit),
        .stat_rd (stat_rd)
    );

    mbox_route_fsm #(.NCHAN(NCHAN), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .submit    (submit),
        .wdata     (wdata),
        .ch_busy   (ch_busy),
        .q_full    (q_full),
        .q_push    (q_push),
        .q_word    (q_word),
        .ch_we     (ch_we),
        .ch_data   (ch_data),
        .drop_full (drop_full_flag),
        .drop_chan (drop_chan_flag)
    );

    mbox_defer_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_word),
        .full      (q_full),
        .empty     (q_empty)
    );

    // Registered read data: status at its offset, zero elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (stat_rd) begin
            rdata                 <= '0;
            rdata[STAT_FULL_BIT]  <= q_full;
            rdata[STAT_EMPTY_BIT] <= q_empty;
        end else begin
            rdata <= '0;
        end
    end

    // Only the two status bits can ever be set (R6).
    p_status_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rdata[29:0] == '0));

    // The queue cannot be full and empty at once (R6).
    p_not_full_and_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));

endmodule

// File: tb/sim_mbox_out_dispatch.sv
`timescale 1ns/1ps
module sim_mbox_out_dispatch;
    localparam int NCHAN = 9;
    localparam int DEPTH = 8;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               wr_en;
    logic               rd_en;
    logic [11:0]        addr;
    logic [31:0]        wdata;
    logic [31:0]        rdata;
    logic [NCHAN-1:0]   ch_busy;
    logic [NCHAN-1:0]   ch_we;
    logic [NCHAN*32-1:0] ch_data;
    logic               drop_full_flag;
    logic               drop_chan_flag;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    mbox_out_dispatch #(.ADDR_W(12), .NCHAN(NCHAN), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ch_busy(ch_busy), .ch_we(ch_we),
        .ch_data(ch_data), .drop_full_flag(drop_full_flag),
        .drop_chan_flag(drop_chan_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write on one edge; returns sampled just after it.
    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset_state();
        logic [31:0] r;
        chk(ch_we == '0, "R7 strobes low", 32'(ch_we), 0);
        chk(!drop_full_flag && !drop_chan_flag, "R7 flags clear",
            {30'd0, drop_full_flag, drop_chan_flag}, 0);
        chk(rdata == 0, "R7 rdata zero", rdata, 0);
        do_read(12'h0B8, r);
        chk(r == 32'h4000_0000, "R6/R7 status empty after reset", r, 32'h4000_0000);
    endtask

    task automatic t_direct();
        do_write(12'h0A0, 32'h1234_5673);
        chk(ch_we == 9'(1 << 3), "R3 strobe ch3", 32'(ch_we), 32'h8);
        chk(ch_data[3*32 +: 32] == 32'h1234_5673, "R3 data ch3",
            ch_data[3*32 +: 32], 32'h1234_5673);
        @(negedge clk);
        chk(ch_we == '0, "R3 single-cycle strobe", 32'(ch_we), 0);
        do_write(12'h0AC, 32'hCAFE_0000);
        chk(ch_we == 9'h001, "R1 offset 0xAC to ch0", 32'(ch_we), 1);
        chk(ch_data[31:0] == 32'hCAFE_0000, "R1 data ch0", ch_data[31:0], 32'hCAFE_0000);
        do_write(12'h1A4, 32'hABCD_0008);
        chk(ch_we == 9'h100, "R9 wrapped offset to ch8", 32'(ch_we), 32'h100);
        chk(ch_data[8*32 +: 32] == 32'hABCD_0008, "R9 data ch8",
            ch_data[8*32 +: 32], 32'hABCD_0008);
    endtask

    task automatic t_ignored();
        logic [31:0] r;
        do_write(12'h0B0, 32'h0000_0002);
        chk(ch_we == '0, "R1 offset 0xB0 ignored", 32'(ch_we), 0);
        do_write(12'h0A2, 32'h0000_0002);
        chk(ch_we == '0, "R1 unaligned 0xA2 ignored", 32'(ch_we), 0);
        do_write(12'h09C, 32'h0000_0002);
        chk(ch_we == '0, "R1 offset 0x9C ignored", 32'(ch_we), 0);
        do_read(12'h0B8, r);
        chk(r == 32'h4000_0000, "R1 queue untouched", r, 32'h4000_0000);
        do_read(12'h09C, r);
        chk(r == 0, "R6 other read returns zero", r, 0);
    endtask

    task automatic t_invalid();
        do_write(12'h0A8, 32'h5555_5559);
        chk(ch_we == '0, "R2 channel 9 no strobe", 32'(ch_we), 0);
        chk(drop_chan_flag == 1'b1, "R2 invalid flag set", 32'(drop_chan_flag), 1);
        chk(drop_full_flag == 1'b0, "R2 full flag untouched", 32'(drop_full_flag), 0);
        do_write(12'h0A0, 32'h0000_000F);
        chk(ch_we == '0, "R2 channel 15 no strobe", 32'(ch_we), 0);
    endtask

    task automatic t_defer();
        logic [31:0] r;
        ch_busy = 9'h020;
        do_write(12'h0A0, 32'h7777_0005);
        chk(ch_we == '0, "R4 busy no strobe", 32'(ch_we), 0);
        do_read(12'h0B8, r);
        chk(r == 32'h0, "R4 queue not empty", r, 0);
        for (int i = 1; i < DEPTH; i++) begin
            do_write(12'h0A4, 32'h7777_0005 + (i << 8));
        end
        do_read(12'h3B8, r);
        chk(r == 32'h8000_0000, "R5/R9 queue full status", r, 32'h8000_0000);
        chk(drop_full_flag == 1'b0, "R5 no drop yet", 32'(drop_full_flag), 0);
        do_write(12'h0A0, 32'h1111_0001);
        chk(ch_we == '0, "R5 idle target dropped when full", 32'(ch_we), 0);
        chk(drop_full_flag == 1'b1, "R5 full flag set", 32'(drop_full_flag), 1);
        do_read(12'h0B8, r);
        chk(r == 32'h8000_0000, "R5 still full", r, 32'h8000_0000);
        ch_busy = '0;
    endtask

    task automatic t_sticky();
        repeat (3) @(negedge clk);
        chk(drop_full_flag && drop_chan_flag, "R8 flags sticky",
            {30'd0, drop_full_flag, drop_chan_flag}, 3);
    endtask

    task automatic t_reset_again();
        logic [31:0] r;
        do_reset();
        chk(!drop_full_flag && !drop_chan_flag, "R7 flags cleared by reset",
            {30'd0, drop_full_flag, drop_chan_flag}, 0);
        do_read(12'h0B8, r);
        chk(r == 32'h4000_0000, "R7 queue emptied by reset", r, 32'h4000_0000);
        do_write(12'h0A0, 32'h0000_0002);
        chk(ch_we == 9'h004, "R3 delivery after reset", 32'(ch_we), 4);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; ch_busy = '0;
        do_reset();
        t_reset_state();
        t_direct();
        t_ignored();
        t_invalid();
        t_defer();
        t_sticky();
        t_reset_again();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule